// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Command Decoder

This block sits behind a serial receiver that has already assembled 24-bit command words. It drives two converter channels. Each channel has three parts. The staging slot holds either a 16-bit code or a pending power-down request. The committed register holds the code the converter is driven with. The committed power state records whether the output is driven or parked.

Every accepted word writes the staging slot that its select bit names. Two per-channel commit flags then copy staging into the committed state. Software can therefore stage both channels and commit them together in one cycle, or update them one at a time. A word with a nonzero reserved bit is discarded as a whole and latches a sticky error indication.

All outputs come from registers and change on the clock edge that samples the command word.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After reset, both committed codes are 0, both power states are 00, both enables are 1 and the error flag is 0.
- R2: An accepted word with both commit flags (bit 21 for channel B, bit 20 for channel A) at 0 changes no output, even though it writes staging.
- R3: A word with exactly one commit flag set updates only that channel's committed code and power state, on the clock edge that samples the word. The other channel's outputs do not change.
- R4: With both commit flags set, both channels commit from their staging slots on the same edge. The channel not selected by bit 18 (0 selects A, 1 selects B) takes the value staged by an earlier word.
- R5: When a word writes a staging slot and commits that same channel, the committed value is the newly written one.
- R6: Power field bits 17:16 nonzero (01 = about 1 kΩ to ground, 10 = about 100 kΩ to ground, 11 = high impedance) stages a power-down request and ignores data bits 15:0. Committing that request sets the power state and leaves the committed code unchanged.
- R7: A channel's enable output is 1 exactly when its committed power state is 00.
- R8: A channel in power-down returns to 00 only on a commit that follows a staging write with power field 00. Committing a staged power-down request again keeps it powered down.
- R9: An accepted word with bits 23:22 nonzero changes no output and sets the error flag. The flag then stays 1 until reset.
- R10: Bit 19 has no effect on any output.
- R11: With the valid input low, the word is ignored and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_word | input | 24 | Command word |
| code_a | output | 16 | Committed code, channel A |
| code_b | output | 16 | Committed code, channel B |
| pwr_a | output | 2 | Committed power state, channel A |
| pwr_b | output | 2 | Committed power state, channel B |
| drive_en_a | output | 1 | Channel A output driven |
| drive_en_b | output | 1 | Channel B output driven |
| rsv_err | output | 1 | Sticky reserved-bit error |

## Verification
The hardest condition to reach is a commit of a channel whose staging slot was last written several words earlier. Such a commit happens only when the other channel is selected and both commit flags, or only the foreign flag, are set.

The stimulus first parks channel B in power-down. It then commits B from a word that writes channel A, which shows that the stale power-down request is re-applied. Next it stages a normal code for B without committing it, and finally commits B through another word aimed at A. The reference model tracks both staging slots so that every one of these commits is predicted.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  localparam int CODE_W  = 16;
  localparam int CMD_W   = 24;
  localparam int NUM_CH  = 2;
  localparam int RSV_HI  = 23;
  localparam int RSV_LO  = 22;
  localparam int LDB_BIT = 21;
  localparam int LDA_BIT = 20;
  localparam int SEL_BIT = 18;
  localparam int PM_HI   = 17;
  localparam int PM_LO   = 16;

  typedef enum logic [1:0] {
    PM_ON      = 2'b00,
    PM_PD_LOW  = 2'b01,
    PM_PD_HIGH = 2'b10,
    PM_HIZ     = 2'b11
  } pmode_e;

  function automatic logic is_parked(input pmode_e m);
    return m != PM_ON;
  endfunction

  // next staging code: a power-down request leaves the stored code alone
  function automatic logic [CODE_W-1:0] stage_code(input pmode_e m,
      input logic [CODE_W-1:0] data, input logic [CODE_W-1:0] old);
    return is_parked(m) ? old : data;
  endfunction
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_ctrl_pkg::*;
(
  input  logic                 cmd_valid,
  input  logic [CMD_W-1:0]     cmd_word,
  output logic                 wr_en,
  output logic                 wr_sel,
  output pmode_e               wr_mode,
  output logic [CODE_W-1:0]    wr_data,
  output logic [NUM_CH-1:0]    ld,
  output logic                 rsv_hit
);
  logic rsv_nz;

  always_comb begin
    rsv_nz  = |cmd_word[RSV_HI:RSV_LO];
    rsv_hit = cmd_valid && rsv_nz;
    wr_en   = cmd_valid && !rsv_nz;
    wr_sel  = cmd_word[SEL_BIT];
    wr_mode = pmode_e'(cmd_word[PM_HI:PM_LO]);
    wr_data = cmd_word[CODE_W-1:0];
    ld      = wr_en ? {cmd_word[LDB_BIT], cmd_word[LDA_BIT]} : '0;
  end
endmodule

// File: rtl/dac_chan_slice.sv
module dac_chan_slice
  import dac_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  pmode_e            wr_mode,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              load,
  output logic [CODE_W-1:0] dac_code,
  output pmode_e            dac_mode,
  output logic              drive_en
);
  pmode_e            stg_mode, stg_mode_nx;
  logic [CODE_W-1:0] stg_code, stg_code_nx;

  always_comb begin
    stg_mode_nx = stg_mode;
    stg_code_nx = stg_code;
    if (wr_en) begin
      stg_mode_nx = wr_mode;
      stg_code_nx = stage_code(wr_mode, wr_data, stg_code);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_mode <= PM_ON;
      stg_code <= '0;
      dac_mode <= PM_ON;
      dac_code <= '0;
    end else begin
      stg_mode <= stg_mode_nx;
      stg_code <= stg_code_nx;
      if (load) begin
        dac_mode <= stg_mode_nx;
        if (!is_parked(stg_mode_nx)) dac_code <= stg_code_nx;
      end
    end
  end

  assign drive_en = !is_parked(dac_mode);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(dac_code) && $stable(dac_mode)));
  assert_pdcode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && stg_mode_nx != PM_ON) |=> $stable(dac_code));
  assert_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && dac_mode != PM_ON && !(wr_en && wr_mode == PM_ON) && stg_mode != PM_ON)
      |=> dac_mode != PM_ON);
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dac_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic [1:0]        pwr_a,
  output logic [1:0]        pwr_b,
  output logic              drive_en_a,
  output logic              drive_en_b,
  output logic              rsv_err
);
  logic              wr_en, wr_sel, rsv_hit;
  pmode_e            wr_mode;
  logic [CODE_W-1:0] wr_data;
  logic [NUM_CH-1:0] ld;

  logic [CODE_W-1:0] ch_code [NUM_CH];
  pmode_e            ch_mode [NUM_CH];
  logic [NUM_CH-1:0] ch_en;

  dac_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_mode   (wr_mode),
    .wr_data   (wr_data),
    .ld        (ld),
    .rsv_hit   (rsv_hit)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    dac_chan_slice u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en && (wr_sel == ch[0])),
      .wr_mode  (wr_mode),
      .wr_data  (wr_data),
      .load     (ld[ch]),
      .dac_code (ch_code[ch]),
      .dac_mode (ch_mode[ch]),
      .drive_en (ch_en[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rsv_err <= 1'b0;
    else if (rsv_hit) rsv_err <= 1'b1;
  end

  assign code_a     = ch_code[0];
  assign code_b     = ch_code[1];
  assign pwr_a      = ch_mode[0];
  assign pwr_b      = ch_mode[1];
  assign drive_en_a = ch_en[0];
  assign drive_en_b = ch_en[1];

  assert_errset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_hit |=> rsv_err);
  assert_errsticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_err |=> rsv_err);
  assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_hit |=> ($stable(code_a) && $stable(code_b) && $stable(pwr_a) && $stable(pwr_b)));
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(code_a) && $stable(code_b) && $stable(pwr_a) && $stable(pwr_b)));
  assert_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en_a) |-> $past(ld[0]));
endmodule

// File: tb/dual_dac_ctrl_bench.sv
`timescale 1ns/1ps
module dual_dac_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic [23:0] cmd_word = '0;
  logic [15:0] code_a, code_b;
  logic [1:0]  pwr_a, pwr_b;
  logic        drive_en_a, drive_en_b, rsv_err;

  int checks = 0;
  int errors = 0;

  int sbuf_mode [2];
  int sbuf_code [2];
  int m_code [2];
  int m_mode [2];
  int m_err;

  always #4 clk = ~clk;

  dual_dac_ctrl u_dual_dac_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .code_a(code_a), .code_b(code_b), .pwr_a(pwr_a), .pwr_b(pwr_b),
    .drive_en_a(drive_en_a), .drive_en_b(drive_en_b), .rsv_err(rsv_err)
  );

  function automatic logic [23:0] mk(int rsv, int ldb, int lda, int x,
                                     int sel, int pm, int data);
    return {rsv[1:0], ldb[0], lda[0], x[0], sel[0], pm[1:0], data[15:0]};
  endfunction

  task automatic model(input logic v, input logic [23:0] w);
    int s, pm;
    if (!v) return;
    if (w[23:22] != 0) begin m_err = 1; return; end
    s = int'(w[18]); pm = int'(w[17:16]);
    sbuf_mode[s] = pm;
    if (pm == 0) sbuf_code[s] = int'(w[15:0]);
    for (int c = 0; c < 2; c++)
      if (w[20+c]) begin
        m_mode[c] = sbuf_mode[c];
        if (sbuf_mode[c] == 0) m_code[c] = sbuf_code[c];
      end
  endtask

  task automatic compare(input string tag);
    logic [37:0] act, exp;
    act = {code_a, code_b, pwr_a, pwr_b, drive_en_a, drive_en_b, rsv_err};
    exp = {m_code[0][15:0], m_code[1][15:0], m_mode[0][1:0], m_mode[1][1:0],
           m_mode[0] == 0, m_mode[1] == 0, m_err[0]};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic v, input logic [23:0] w, input string tag);
    cmd_valid = v; cmd_word = w;
    @(posedge clk);
    model(v, w);
    @(negedge clk);
    cmd_valid = 0;
    compare(tag);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      sbuf_mode[c] = 0; sbuf_code[c] = 0; m_code[c] = 0; m_mode[c] = 0;
    end
    m_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1 reset");
    send(1, mk(0,0,0,0,0,0,'h1234), "R2 stage A only");
    send(1, mk(0,0,0,0,1,0,'hBEEF), "R2 stage B only");
    send(1, mk(0,1,1,0,1,0,'hBEEF), "R4 commit both");
    send(1, mk(0,0,1,0,0,0,'h5555), "R5 R3 write and commit A");
    send(1, mk(0,0,1,1,0,0,'h0100), "R10 bit19 set");
    send(0, mk(0,1,1,0,1,0,'h9999), "R11 valid low");
    send(1, mk(2,1,1,0,1,0,'h2222), "R9 reserved ignored");
    send(1, mk(0,1,0,0,1,2,'hFFFF), "R6 R7 park B");
    send(1, mk(0,1,0,0,0,0,'h7777), "R8 recommit parked B");
    send(1, mk(0,0,0,0,1,0,'h4321), "R8 stage only stays parked");
    send(1, mk(0,1,0,0,0,0,'h7777), "R8 exit via commit");
    send(1, mk(0,0,1,0,0,1,'h0000), "R6 mode 01 A");
    send(1, mk(0,1,1,0,0,3,'hAAAA), "R6 R4 hiz A with B");
    send(1, mk(1,0,0,0,0,0,'h0000), "R9 sticky");
    send(1, mk(0,0,1,0,0,0,'h8001), "R8 R7 A back on");
    repeat (3) begin @(negedge clk); compare("R11 idle"); end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule